// File: doc/BRIEF.md
# Inbound Address Window Decoder

This block decides whether an address arriving from the peripheral bus side falls inside one of three programmable memory windows, and if so which one, and what host-memory address it becomes. Every window is set up by a single 32-bit word that carries a base address at 1 MB granularity and a 4-bit power-of-two size code. A fourth word with the same layout describes a window in I/O space. Host memory behind every window begins at address zero, so the translated address is simply the offset of the incoming address within its window.

Software loads the window words through a small write port and can read any of them back. A lookup is presented on the request inputs together with a flag that selects memory or I/O space. One clock later the decoder reports whether a window matched, the index of the winning window and the translated address. When memory windows overlap, the one with the lowest index wins. The base is not forced to be aligned to the window size: base bits below the size boundary take no part in the comparison.

Top module: `inbound_window_decoder`

## Requirements
- R1: After reset every window (indices 0 to 3) is disabled, every readback word is 0 and lk_valid is 0; no lookup hits until a window is written.
- R2: A write to index 0..2 (memory) or 3 (I/O) stores data bits 31..20 as the base and bits 19..16 as the size code; readback returns those bits in the same positions and zeros in bits 15..0, one cycle after cfg_rsel is sampled.
- R3: A window with code c matches when address bits 31..(20+c) equal the same bits of the base; base bits below 20+c are ignored, so a base not aligned to the size still yields a size-aligned window.
- R4: Size code c selects a window of 1 MB shifted left by c, from 0x0 (1 MB) up to 0xB (2 GB); the first and last address of a window hit and the address one past its end does not.
- R5: A write with a size code above 0xB disables that window; it never hits until a legal code is written.
- R6: When several memory windows match, the lowest index is reported.
- R7: On a hit lk_host_addr is the incoming address with all bits at and above 20+c cleared; on a miss lk_hit is 0, lk_win is 0 and lk_host_addr is 0.
- R8: lk_valid equals req_valid of the previous cycle; results appear exactly one cycle after the request is sampled.
- R9: With req_io set only the I/O window (index 3) is considered and a hit reports lk_win = 3; with req_io clear only windows 0..2 are considered.
- R10: A write acts on lookups sampled after the write edge; a lookup sampled on the same edge as a write uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window word write strobe |
| cfg_wsel | input | 2 | Window index to write (0..2 memory, 3 I/O) |
| cfg_wdata | input | 32 | Window word: base in 31..20, size code in 19..16 |
| cfg_rsel | input | 2 | Window index to read back |
| cfg_rdata | output | 32 | Registered readback of the selected window word |
| req_valid | input | 1 | Lookup request strobe |
| req_io | input | 1 | Lookup targets I/O space (1) or memory space (0) |
| req_addr | input | 32 | Incoming bus-side address |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Address fell inside an enabled window |
| lk_win | output | 2 | Index of the matching window |
| lk_host_addr | output | 32 | Translated host address (offset within window) |

## Verification
The hardest situation to reach is an address claimed by more than one enabled window whose bases are not aligned to their sizes, since random words rarely produce overlapping windows. The stimulus therefore sets up overlaps and a misaligned base by direct writes, disables the winning window with an illegal code to expose the next one, and in the random phase draws half of the lookup addresses from just inside the currently programmed bases, so overlapping and boundary hits occur often. A write and a lookup are also presented on the same edge to show which contents the lookup sees.

// File: rtl/inwin_pkg.sv
package inwin_pkg;
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_BASE_LSB = 20;
  localparam int unsigned DEF_CODE_W   = 4;
  localparam int unsigned DEF_MAX_CODE = 11;
  localparam int unsigned DEF_NUM_WIN  = 3;

  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } space_e;
endpackage

// File: rtl/inwin_reg_bank.sv
module inwin_reg_bank #(
  parameter int unsigned ADDR_W   = inwin_pkg::DEF_ADDR_W,
  parameter int unsigned BASE_LSB = inwin_pkg::DEF_BASE_LSB,
  parameter int unsigned CODE_W   = inwin_pkg::DEF_CODE_W,
  parameter int unsigned MAX_CODE = inwin_pkg::DEF_MAX_CODE,
  parameter int unsigned NUM_ENT  = 4,
  parameter int unsigned SEL_W    = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [SEL_W-1:0]                  wsel,
  input  logic [ADDR_W-1:0]                 wdata,
  input  logic [SEL_W-1:0]                  rsel,
  output logic [ADDR_W-1:0]                 rdata,
  output logic [NUM_ENT*(ADDR_W-BASE_LSB)-1:0] base_flat,
  output logic [NUM_ENT*CODE_W-1:0]         code_flat,
  output logic [NUM_ENT-1:0]                en_vec
);
  localparam int unsigned BASE_W = ADDR_W - BASE_LSB;
  localparam int unsigned PAD_W  = BASE_LSB - CODE_W;

  logic [BASE_W-1:0] base_q [NUM_ENT];
  logic [CODE_W-1:0] code_q [NUM_ENT];
  logic [NUM_ENT-1:0] en_q;

  logic [CODE_W-1:0] wcode;
  logic              unused_wdata_low;
  assign wcode            = wdata[BASE_LSB-1 -: CODE_W];
  assign unused_wdata_low = ^wdata[PAD_W-1:0];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        code_q[g] <= '0;
        en_q[g]   <= 1'b0;
      end else if (we && (wsel == SEL_W'(g))) begin
        base_q[g] <= wdata[ADDR_W-1:BASE_LSB];
        code_q[g] <= wcode;
        en_q[g]   <= (32'(wcode) <= MAX_CODE);
      end
    end
    assign base_flat[g*BASE_W +: BASE_W] = base_q[g];
    assign code_flat[g*CODE_W +: CODE_W] = code_q[g];
  end

  assign en_vec = en_q;

  logic [ADDR_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (rsel == SEL_W'(i)) rd_word = {base_q[i], code_q[i], {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end
endmodule

// File: rtl/inwin_match.sv
module inwin_match #(
  parameter int unsigned ADDR_W   = inwin_pkg::DEF_ADDR_W,
  parameter int unsigned BASE_LSB = inwin_pkg::DEF_BASE_LSB,
  parameter int unsigned CODE_W   = inwin_pkg::DEF_CODE_W
) (
  input  logic                       en,
  input  logic [ADDR_W-BASE_LSB-1:0] base,
  input  logic [CODE_W-1:0]          code,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit,
  output logic [ADDR_W-1:0]          offset
);
  localparam int unsigned SH_W = $clog2(ADDR_W + 1);

  logic [SH_W-1:0]   shamt;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] base_full;

  assign shamt     = SH_W'(BASE_LSB) + SH_W'(code);
  assign low_mask  = (shamt >= SH_W'(ADDR_W)) ? '1 : ((ADDR_W'(1) << shamt) - ADDR_W'(1));
  assign base_full = {base, {BASE_LSB{1'b0}}};
  assign hit       = en && ((addr & ~low_mask) == (base_full & ~low_mask));
  assign offset    = addr & low_mask;
endmodule

// File: rtl/inwin_prio.sv
module inwin_prio #(
  parameter int unsigned ADDR_W  = inwin_pkg::DEF_ADDR_W,
  parameter int unsigned NUM_WIN = inwin_pkg::DEF_NUM_WIN,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [NUM_WIN-1:0]        hits,
  input  logic [NUM_WIN*ADDR_W-1:0] offsets,
  output logic                      any,
  output logic [IDX_W-1:0]          idx,
  output logic [ADDR_W-1:0]         offset
);
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    offset = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any    = 1'b1;
        idx    = IDX_W'(i);
        offset = offsets[i*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/inbound_window_decoder.sv
module inbound_window_decoder #(
  parameter int unsigned ADDR_W   = inwin_pkg::DEF_ADDR_W,
  parameter int unsigned BASE_LSB = inwin_pkg::DEF_BASE_LSB,
  parameter int unsigned CODE_W   = inwin_pkg::DEF_CODE_W,
  parameter int unsigned MAX_CODE = inwin_pkg::DEF_MAX_CODE,
  parameter int unsigned NUM_WIN  = inwin_pkg::DEF_NUM_WIN,
  parameter int unsigned SEL_W    = $clog2(NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_wsel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [SEL_W-1:0]  cfg_rsel,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              lk_valid,
  output logic              lk_hit,
  output logic [SEL_W-1:0]  lk_win,
  output logic [ADDR_W-1:0] lk_host_addr
);
  localparam int unsigned NUM_ENT = NUM_WIN + 1;
  localparam int unsigned BASE_W  = ADDR_W - BASE_LSB;
  localparam int unsigned IO_IDX  = NUM_WIN;

  logic [NUM_ENT*BASE_W-1:0] base_flat;
  logic [NUM_ENT*CODE_W-1:0] code_flat;
  logic [NUM_ENT-1:0]        en_vec;

  inwin_reg_bank #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .CODE_W(CODE_W),
    .MAX_CODE(MAX_CODE), .NUM_ENT(NUM_ENT), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .we(cfg_we), .wsel(cfg_wsel), .wdata(cfg_wdata),
    .rsel(cfg_rsel), .rdata(cfg_rdata),
    .base_flat(base_flat), .code_flat(code_flat), .en_vec(en_vec)
  );

  logic [NUM_ENT-1:0]        raw_hit;
  logic [NUM_ENT*ADDR_W-1:0] raw_off;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_win
    inwin_match #(
      .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .CODE_W(CODE_W)
    ) u_match (
      .en(en_vec[g]),
      .base(base_flat[g*BASE_W +: BASE_W]),
      .code(code_flat[g*CODE_W +: CODE_W]),
      .addr(req_addr),
      .hit(raw_hit[g]),
      .offset(raw_off[g*ADDR_W +: ADDR_W])
    );
  end

  logic [NUM_WIN-1:0] mem_hits;
  logic               mem_any;
  logic [SEL_W-1:0]   mem_idx;
  logic [ADDR_W-1:0]  mem_off;

  assign mem_hits = raw_hit[NUM_WIN-1:0] & {NUM_WIN{req_io == inwin_pkg::SPACE_MEM}};

  inwin_prio #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .IDX_W(SEL_W)
  ) u_prio (
    .hits(mem_hits),
    .offsets(raw_off[NUM_WIN*ADDR_W-1:0]),
    .any(mem_any), .idx(mem_idx), .offset(mem_off)
  );

  logic              nx_hit;
  logic [SEL_W-1:0]  nx_win;
  logic [ADDR_W-1:0] nx_addr;

  always_comb begin
    nx_hit  = 1'b0;
    nx_win  = '0;
    nx_addr = '0;
    if (req_io == inwin_pkg::SPACE_IO) begin
      if (raw_hit[IO_IDX]) begin
        nx_hit  = 1'b1;
        nx_win  = SEL_W'(IO_IDX);
        nx_addr = raw_off[IO_IDX*ADDR_W +: ADDR_W];
      end
    end else if (mem_any) begin
      nx_hit  = 1'b1;
      nx_win  = mem_idx;
      nx_addr = mem_off;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid     <= 1'b0;
      lk_hit       <= 1'b0;
      lk_win       <= '0;
      lk_host_addr <= '0;
    end else begin
      lk_valid     <= req_valid;
      lk_hit       <= req_valid && nx_hit;
      lk_win       <= (req_valid && nx_hit) ? nx_win : '0;
      lk_host_addr <= (req_valid && nx_hit) ? nx_addr : '0;
    end
  end
endmodule

// File: rtl/inwin_checker.sv
module inwin_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned NUM_WIN = 3,
  parameter int unsigned PAD_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_io,
  input logic [ADDR_W-1:0] cfg_rdata,
  input logic              lk_valid,
  input logic              lk_hit,
  input logic [SEL_W-1:0]  lk_win,
  input logic [ADDR_W-1:0] lk_host_addr
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!lk_valid && !lk_hit && cfg_rdata == '0));

  assert_rd_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[PAD_W-1:0] == '0);

  assert_offset_span_R4: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> !lk_host_addr[ADDR_W-1]);

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_hit) |-> (lk_win == '0 && lk_host_addr == '0));

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> lk_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!lk_valid && !lk_hit));

  assert_io_index_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_io) |=> (!lk_hit || lk_win == SEL_W'(NUM_WIN)));

  assert_mem_index_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_io) |=> (!lk_hit || lk_win < SEL_W'(NUM_WIN)));
endmodule

bind inbound_window_decoder inwin_checker #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NUM_WIN(NUM_WIN), .PAD_W(BASE_LSB - CODE_W)
) u_inwin_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_io(req_io),
  .cfg_rdata(cfg_rdata), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_win(lk_win), .lk_host_addr(lk_host_addr)
);

// File: tb/inbound_window_decoder_tb.sv
module inbound_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_wsel;
  logic [31:0] cfg_wdata;
  logic [1:0]  cfg_rsel;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic        req_io;
  logic [31:0] req_addr;
  logic        lk_valid;
  logic        lk_hit;
  logic [1:0]  lk_win;
  logic [31:0] lk_host_addr;

  int n_chk  = 0;
  int n_fail = 0;

  logic [11:0] m_base [4];
  logic [3:0]  m_code [4];
  bit          m_en   [4];

  always #2 clk = ~clk;

  inbound_window_decoder dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_wsel(cfg_wsel), .cfg_wdata(cfg_wdata),
    .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_io(req_io), .req_addr(req_addr),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_win(lk_win), .lk_host_addr(lk_host_addr)
  );

  function automatic void model_lookup(input logic [31:0] a, input bit io,
                                       output bit h, output logic [1:0] w,
                                       output logic [31:0] o);
    h = 1'b0; w = 2'd0; o = 32'd0;
    for (int i = 0; i < 4; i++) begin
      if (!h && m_en[i] && ((i == 3) == io)) begin
        int sh = 20 + int'(m_code[i]);
        logic [31:0] lm = (32'h1 << sh) - 32'h1;
        if ((a & ~lm) == ({m_base[i], 20'h0} & ~lm)) begin
          h = 1'b1; w = 2'(i); o = a & lm;
        end
      end
    end
  endfunction

  function automatic void model_write(input logic [1:0] s, input logic [31:0] d);
    m_base[s] = d[31:20];
    m_code[s] = d[19:16];
    m_en[s]   = (d[19:16] <= 4'hB);
  endfunction

  task automatic check(input string req, input bit ok, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = s; cfg_wdata = d;
    @(posedge clk);
    model_write(s, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_read(input string req, input logic [1:0] s);
    logic [31:0] e;
    @(negedge clk);
    cfg_rsel = s;
    @(posedge clk);
    @(negedge clk);
    e = {m_base[s], m_code[s], 16'h0};
    check(req, cfg_rdata == e, 64'(cfg_rdata), 64'(e));
  endtask

  task automatic check_lookup(input string req, input logic [31:0] a, input bit io);
    bit h; logic [1:0] w; logic [31:0] o;
    @(negedge clk);
    model_lookup(a, io, h, w, o);
    req_valid = 1'b1; req_io = io; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, lk_valid && lk_hit == h && lk_win == w && lk_host_addr == o,
          {lk_valid, lk_hit, lk_win, 28'h0, lk_host_addr},
          {1'b1, h, w, 28'h0, o});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit h; logic [1:0] w; logic [31:0] o;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_code[i] = '0; m_en[i] = 1'b0;
    end
    rst = 1'b1; cfg_we = 1'b0; cfg_wsel = '0; cfg_wdata = '0; cfg_rsel = '0;
    req_valid = 1'b0; req_io = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 lk_valid after reset", lk_valid == 1'b0, 64'(lk_valid), 64'd0);
    for (int s = 0; s < 4; s++) check_read("R1 readback zero", 2'(s));
    check_lookup("R1 all disabled miss mem", 32'h0000_0000, 1'b0);
    check_lookup("R1 all disabled miss io", 32'h0000_0000, 1'b1);

    // R10: write and lookup on the same edge
    cfg_write(2'd0, 32'h1000_0000);
    @(negedge clk);
    model_lookup(32'h2000_0010, 1'b0, h, w, o);
    cfg_we = 1'b1; cfg_wsel = 2'd0; cfg_wdata = 32'h2000_0000;
    req_valid = 1'b1; req_io = 1'b0; req_addr = 32'h2000_0010;
    @(posedge clk);
    model_write(2'd0, 32'h2000_0000);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R10 same-edge lookup sees old", lk_valid && lk_hit == h && !h,
          64'(lk_hit), 64'(h));
    check_lookup("R10 next lookup sees new", 32'h2000_0010, 1'b0);

    // R2: stored fields and zero low bits
    cfg_write(2'd0, 32'h1005_ABCD);
    check_read("R2 readback fields", 2'd0);
    // R4: 32 MB window boundaries
    check_lookup("R4 first address", 32'h1000_0000, 1'b0);
    check_lookup("R4 last address", 32'h11FF_FFFF, 1'b0);
    check_lookup("R4 one past end", 32'h1200_0000, 1'b0);
    check_lookup("R4 below start", 32'h0FFF_FFFF, 1'b0);

    // R3: misaligned base, 256 MB window
    cfg_write(2'd1, 32'h0F08_0000);
    check_lookup("R3 misaligned base low end", 32'h0000_1234, 1'b0);
    check_lookup("R3 misaligned base top", 32'h0FFF_FFF0, 1'b0);

    // R6: overlap, lowest index wins
    cfg_write(2'd2, 32'h1000_0000);
    check_lookup("R6 overlap lowest index", 32'h1000_0040, 1'b0);
    // R5: illegal codes disable
    cfg_write(2'd0, 32'h100C_0000);
    check_read("R5 readback illegal code", 2'd0);
    check_lookup("R5 code 0xC disabled, next window", 32'h1000_0040, 1'b0);
    check_lookup("R5 code 0xC no hit inside old span", 32'h1010_0000, 1'b0);
    cfg_write(2'd2, 32'h100F_0000);
    check_lookup("R5 code 0xF disabled", 32'h1000_0040, 1'b0);

    // R4: largest code
    cfg_write(2'd0, 32'h800B_0000);
    check_lookup("R4 2GB window top", 32'hFFFF_FFFF, 1'b0);
    check_lookup("R4 2GB window bottom", 32'h8000_0000, 1'b0);
    check_lookup("R7 miss outside all", 32'h7FFF_FFFF, 1'b0);

    // R9: I/O window separate from memory
    cfg_write(2'd3, 32'h0000_0000);
    check_lookup("R9 io hit index 3", 32'h0000_1234, 1'b1);
    check_lookup("R9 mem same addr uses mem window", 32'h0000_1234, 1'b0);
    check_lookup("R9 io miss outside io window", 32'h8000_0040, 1'b1);
    check_read("R9 io readback", 2'd3);

    // R8: idle cycle gives no valid
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 idle no valid", !lk_valid && !lk_hit, {62'h0, lk_valid, lk_hit}, 64'd0);

    // Random phase: R3 R4 R5 R6 R7 R9
    for (int it = 0; it < 3000; it++) begin
      logic [31:0] a;
      int pick;
      if (($urandom % 8) == 0) begin
        logic [31:0] d = $urandom;
        if (($urandom % 4) != 0) d[19:16] = 4'($urandom % 12);
        cfg_write(2'($urandom % 4), d);
      end
      pick = int'($urandom % 4);
      a = $urandom;
      if (($urandom % 2) == 0) begin
        a = {m_base[pick], 20'h0} ^ ($urandom & ((32'h1 << ($urandom % 24)) - 1));
      end
      check_lookup("R7 random lookup", a, ($urandom % 4) == 0);
    end
    for (int s = 0; s < 4; s++) check_read("R2 random readback", 2'(s));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule